// File: doc/BRIEF.md
# Arithmetic AES Byte Substitution Unit

This block produces the AES byte substitution and its inverse for one byte at a time. It does not use a stored table. Instead it computes the result with field arithmetic in GF(2^8), reduced by x^8 + x^4 + x^3 + x + 1. In the forward direction the byte is inverted in the field and then passed through the affine map over GF(2). In the inverse direction the byte first goes through the inverse affine map and is then inverted. Both directions share one inverter.

The inverter raises the operand to the power 254 by left-to-right square-and-multiply. It handles one exponent bit per clock, so a result takes 8 cycles. The zero byte has no field inverse, and the exponentiation maps it to zero.

A caller raises `valid_i` together with the byte and the direction bit while `ready_o` is high. The result appears on `data_o` with a one-cycle `valid_o` pulse. `data_o` keeps that value until the next result.

Top module: `sbox_gf`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `valid_o`=0, `ready_o`=1 and `data_o`=0x00. Pulling `rst_ni` low during a computation abandons it, and no `valid_o` follows.
- R2: With `inv_i`=0 (forward), the inputs 0x00, 0x01 and 0x53 give 0x63, 0x7C and 0xED. The forward map is the field inverse (with 0x00 mapped to 0x00), followed by out bit i = b_i ^ b_(i+4) ^ b_(i+5) ^ b_(i+6) ^ b_(i+7) ^ c_i, where indices are taken mod 8 and c = 0x63.
- R3: With `inv_i`=1 (inverse), the inputs 0x63, 0x7C and 0xED give 0x00, 0x01 and 0x53. The inverse map applies out bit i = b_(i+2) ^ b_(i+5) ^ b_(i+7) ^ d_i, with d = 0x05, and then takes the field inverse.
- R4: For all 256 byte values x, the inverse applied to the forward result of x returns x.
- R5: An input is accepted on a rising edge where `valid_i`=1 and `ready_o`=1. `valid_o` goes high after the 8th rising edge following the accepting edge, and it stays high for exactly one cycle.
- R6: `ready_o` is low from the edge after acceptance until the result edge. A `valid_i` presented while `ready_o` is low is ignored: it changes neither the pending result nor the number of `valid_o` pulses.
- R7: `data_o` changes only on the edge where `valid_o` rises, and it holds the last result between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input byte present |
| inv_i | input | 1 | 0 selects forward substitution, 1 selects inverse |
| data_i | input | 8 | Input byte |
| ready_o | output | 1 | Unit idle, input can be accepted |
| valid_o | output | 1 | One-cycle pulse when a result is ready |
| data_o | output | 8 | Result byte, held until the next result |

## Verification
The hardest condition to reach is a request that arrives while the exponentiation is in flight. It must leave both the pending result and the pulse count untouched. The bench holds `valid_i` high with a different byte for several cycles in the middle of a computation. It then drops `valid_i` before the unit goes idle, checks the original result, and confirms that no second pulse follows.

A reset during a computation is forced the same way, by pulling `rst_ni` low a few cycles after acceptance. Exhaustive round trips cover all 256 bytes, including the zero byte that has no inverse.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [8:0]  RED_POLY = 9'h11B;
  // Rotation-tap masks: bit j set means input bit (i+j) mod W feeds output bit i
  localparam logic [7:0]  FWD_TAPS  = 8'hF1;
  localparam logic [7:0]  FWD_CONST = 8'h63;
  localparam logic [7:0]  INV_TAPS  = 8'hA4;
  localparam logic [7:0]  INV_CONST = 8'h05;

  typedef enum logic {DIR_FWD = 1'b0, DIR_INV = 1'b1} dir_e;
endpackage

// File: rtl/gf_mul.sv
module gf_mul #(
  parameter int unsigned W    = 8,
  parameter logic [W:0]  POLY = 9'h11B
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);
  always_comb begin
    logic [W-1:0] acc;
    logic [W-1:0] t;
    acc = '0;
    t   = a_i;
    for (int k = 0; k < W; k++) begin
      if (b_i[k]) acc = acc ^ t;
      t = {t[W-2:0], 1'b0} ^ (t[W-1] ? POLY[W-1:0] : '0);
    end
    p_o = acc;
  end
endmodule

// File: rtl/gf_affine.sv
module gf_affine #(
  parameter int unsigned W     = 8,
  parameter logic [W-1:0] TAPS = 8'hF1,
  parameter logic [W-1:0] CVEC = 8'h63
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      logic acc;
      acc = CVEC[i];
      for (int j = 0; j < W; j++)
        if (TAPS[j]) acc = acc ^ d_i[(i + j) % W];
      d_o[i] = acc;
    end
  end
endmodule

// File: rtl/gf_inv_seq.sv
module gf_inv_seq #(
  parameter int unsigned W    = 8,
  parameter logic [W:0]  POLY = 9'h11B
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] op_i,
  output logic         busy_o,
  output logic         last_o,
  output logic [W-1:0] res_o
);
  localparam int unsigned IW = $clog2(W);
  localparam logic [W-1:0] EXP = {{(W-1){1'b1}}, 1'b0};  // 2^W - 2

  logic [W-1:0]  base_q, acc_q, sq, sqm;
  logic [IW-1:0] idx_q;
  logic          busy_q;

  gf_mul #(.W(W), .POLY(POLY)) u_sq  (.a_i(acc_q), .b_i(acc_q),  .p_o(sq));
  gf_mul #(.W(W), .POLY(POLY)) u_mul (.a_i(sq),    .b_i(base_q), .p_o(sqm));

  assign res_o  = EXP[idx_q] ? sqm : sq;
  assign busy_o = busy_q;
  assign last_o = busy_q && (idx_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      acc_q  <= '0;
      base_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      idx_q  <= IW'(W - 1);
      acc_q  <= W'(1);
      base_q <= op_i;
    end else if (busy_q) begin
      acc_q <= res_o;
      idx_q <= idx_q - 1'b1;
      if (idx_q == '0) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sbox_gf.sv
module sbox_gf
  import sbox_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         inv_i,
  input  logic [W-1:0] data_i,
  output logic         ready_o,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic         busy, last, accept;
  logic [W-1:0] pre_inv, pre_op, inv_res, post_fwd;
  dir_e         dir_q;
  logic         valid_q;
  logic [W-1:0] data_q;

  assign accept = valid_i && !busy;

  gf_affine #(.W(W), .TAPS(INV_TAPS[W-1:0]), .CVEC(INV_CONST[W-1:0]))
    u_pre (.d_i(data_i), .d_o(pre_inv));

  assign pre_op = inv_i ? pre_inv : data_i;

  gf_inv_seq #(.W(W), .POLY(RED_POLY)) u_inv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .op_i   (pre_op),
    .busy_o (busy),
    .last_o (last),
    .res_o  (inv_res)
  );

  gf_affine #(.W(W), .TAPS(FWD_TAPS[W-1:0]), .CVEC(FWD_CONST[W-1:0]))
    u_post (.d_i(inv_res), .d_o(post_fwd));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= DIR_FWD;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (accept) dir_q <= inv_i ? DIR_INV : DIR_FWD;
      valid_q <= last;
      if (last) data_q <= (dir_q == DIR_INV) ? inv_res : post_fwd;
    end
  end

  assign ready_o = !busy;
  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/sbox_gf_chk.sv
module sbox_gf_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         ready_o,
  input logic         valid_o,
  input logic [W-1:0] data_o
);
  localparam int unsigned CW = $clog2(W + 2) + 1;
  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cyc_q <= '0;
    else if (valid_i && ready_o) cyc_q <= CW'(1);
    else if (valid_o)           cyc_q <= '0;
    else if (cyc_q != '0)       cyc_q <= cyc_q + 1'b1;
  end

  p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cyc_q == CW'(W + 1)));
  p_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_busy_after_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);
  p_idle_on_result_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ready_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && ready_o && data_o == '0));
endmodule

bind sbox_gf sbox_gf_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .ready_o(ready_o),
  .valid_o(valid_o),
  .data_o (data_o)
);

// File: tb/sim_sbox_gf.sv
module sim_sbox_gf;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic       inv_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       ready_o, valid_o;
  logic [7:0] data_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  sbox_gf u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one request; returns result and number of negedges until valid_o
  task automatic run_op(input bit inv, input logic [7:0] din,
                        output logic [7:0] res, output int lat);
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    valid_i = 1'b1; inv_i = inv; data_i = din;
    @(negedge clk_i);
    valid_i = 1'b0;
    lat = 1;
    while (!valid_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
    end
    res = data_o;
  endtask

  task automatic t_reset;
    check(!valid_o, "R1 valid_o in reset", valid_o, 0);
    check(ready_o, "R1 ready_o in reset", ready_o, 1);
    check(data_o == 8'h00, "R1 data_o in reset", data_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    check(!valid_o && ready_o && data_o == 8'h00, "R1 after release",
          {valid_o, ready_o, data_o}, 10'h100);
  endtask

  task automatic t_known(input bit inv, input logic [7:0] din, input logic [7:0] exp,
                         input string req);
    logic [7:0] r;
    int l;
    run_op(inv, din, r, l);
    check(r == exp, req, r, exp);
  endtask

  task automatic t_latency;
    logic [7:0] r;
    int l;
    run_op(1'b0, 8'h01, r, l);
    check(l == 9, "R5 latency", l, 9);
    @(negedge clk_i);
    check(!valid_o, "R5 single pulse", valid_o, 0);
  endtask

  task automatic t_busy_ignore;
    int pulses = 0;
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    valid_i = 1'b1; inv_i = 1'b0; data_i = 8'h53;
    @(negedge clk_i);
    check(!ready_o, "R6 ready_o low while busy", ready_o, 0);
    data_i = 8'h00; inv_i = 1'b1;
    repeat (5) @(negedge clk_i);
    valid_i = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (valid_o) begin
        pulses++;
        check(data_o == 8'hED, "R6 pending result untouched", data_o, 8'hED);
      end
      @(negedge clk_i);
    end
    check(pulses == 1, "R6 pulse count", pulses, 1);
    check(ready_o, "R6 idle after result", ready_o, 1);
  endtask

  task automatic t_hold;
    logic [7:0] r;
    int l;
    run_op(1'b0, 8'h53, r, l);
    repeat (6) @(negedge clk_i);
    check(data_o == r && !valid_o, "R7 data_o held", data_o, r);
  endtask

  task automatic t_reset_mid;
    int pulses = 0;
    @(negedge clk_i);
    valid_i = 1'b1; inv_i = 1'b0; data_i = 8'h01;
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(!valid_o && ready_o && data_o == 8'h00, "R1 reset mid-op",
          {valid_o, ready_o, data_o}, 10'h100);
    rst_ni = 1'b1;
    for (int k = 0; k < 15; k++) begin
      if (valid_o) pulses++;
      @(negedge clk_i);
    end
    check(pulses == 0, "R1 abandoned op yields no pulse", pulses, 0);
  endtask

  task automatic t_roundtrip;
    int errs = 0;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] y, z;
      int l;
      run_op(1'b0, 8'(x), y, l);
      run_op(1'b1, y, z, l);
      if (z != 8'(x)) begin
        errs++;
        check(1'b0, "R4 round trip", z, x);
      end
    end
    check(errs == 0, "R4 round trip all bytes", errs, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        t_reset();
        t_known(1'b0, 8'h00, 8'h63, "R2 fwd 00");
        t_known(1'b0, 8'h01, 8'h7C, "R2 fwd 01");
        t_known(1'b0, 8'h53, 8'hED, "R2 fwd 53");
        t_known(1'b1, 8'h63, 8'h00, "R3 inv 63");
        t_known(1'b1, 8'h7C, 8'h01, "R3 inv 7C");
        t_known(1'b1, 8'hED, 8'h53, "R3 inv ED");
        t_latency();
        t_busy_ignore();
        t_hold();
        t_reset_mid();
        t_roundtrip();
      end
      begin
        repeat (100000) @(posedge clk_i);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule